// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the program order of instructions that an out-of-order core executes. Dispatch claims consecutive slots in a circular buffer. Writeback later reports each slot as finished, together with its result value or store data, a target address, and flags for a wrong branch guess or an exception. Each cycle the block looks at a window of slots starting at the oldest one. It retires completed instructions from that window in order. For each retired instruction it either writes the architectural register file or hands the store to the data cache.

A retirement group ends at the first slot that has not finished. It also ends at a branch: the branch retires, and nothing after it retires in that cycle. When the oldest slot carries a wrong-guess or exception flag, that slot does not retire. Instead the block raises a pipeline flush that carries the restart address written back for that slot, and it empties the buffer in the same step. Branch prediction, the cache and the register file itself sit outside the block and connect only through these plain ports.

Top module: `rob_retire`

## Requirements
- R1: Up to CW completed instructions retire per cycle, strictly in allocation order starting at the oldest slot. `ret_mask` is always a low-first prefix, and slot i of the retire ports is the i-th oldest retiring instruction.
- R2: Retirement stops at the first slot that has not completed. Completed slots behind it wait, even when they lie inside the window.
- R3: A branch (kind code 2'b01) may retire, but no instruction behind it retires in the same cycle.
- R4: If the oldest slot is flagged (by wb_mispred or wb_trap), nothing retires that cycle and, one cycle later, `flush` is high for one cycle with `flush_pc` equal to the wb_addr recorded for that slot. A flagged slot that is not the oldest ends the group in front of it.
- R5: A flush empties the buffer. While `flush` is high, `alloc_base` is 0 and `full` is 0, and no instruction allocated before the flush ever retires.
- R6: A retiring instruction of kind 2'b00 (plain op) asserts `rf_we` in its slot, with `rf_waddr` set to its destination register and `rf_wdata` set to the value written back for it.
- R7: A retiring store (kind 2'b10) asserts `st_valid` in its slot, with the written-back address and data, and never asserts `rf_we`. A completed store that has not retired produces no `st_valid`.
- R8: `full` is high when fewer than DW slots are free. While `full` is high, a dispatch is ignored and `alloc_base` does not move.
- R9: The valid dispatch lanes are packed low-first. Lane j gets slot (alloc_base + j) mod DEPTH, and `alloc_base` advances by the number of valid lanes.
- R10: After reset, `alloc_base` is 0 and `full`, `flush`, `ret_mask`, `rf_we` and `st_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_vld | input | DW | Dispatch lane valid, packed low-first |
| disp_kind | input | 2*DW | Per-lane kind: 00 plain op, 01 branch, 10 store |
| disp_areg | input | AREG_W*DW | Per-lane architectural destination |
| full | output | 1 | Fewer than DW free slots |
| alloc_base | output | log2(DEPTH) | Slot index given to dispatch lane 0 |
| wb_valid | input | 1 | Writeback report valid |
| wb_idx | input | log2(DEPTH) | Slot being reported |
| wb_value | input | DATA_W | Result value or store data |
| wb_addr | input | ADDR_W | Restart target, or store address |
| wb_mispred | input | 1 | Branch was guessed wrong |
| wb_trap | input | 1 | Instruction raised an exception |
| ret_mask | output | CW | Retired in this cycle, per slot |
| rf_we | output | CW | Register file write enable, per slot |
| rf_waddr | output | AREG_W*CW | Register file write address |
| rf_wdata | output | DATA_W*CW | Register file write data |
| st_valid | output | CW | Store released to the data cache |
| st_addr | output | ADDR_W*CW | Store address |
| st_data | output | DATA_W*CW | Store data |
| flush | output | 1 | Pipeline flush pulse |
| flush_pc | output | ADDR_W | Restart address for the flush |

## Verification
Plain ops are written back in reverse order to show that the oldest unfinished slot holds the whole window back, and a gap in the middle of the window shows that the group stops there. Branches placed first and then second in a group tell the branch rule apart from the width limit. A store next to a plain op separates the cache path from the register path. A wrong-guess branch behind a retiring op, and an exception in the second window slot, each show the retire-then-flush order and the restart target. Filling the buffer to one free slot, and a flush that wraps the pointers, exercise the full limit, the ignored dispatch and the clearing.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_OP  = 2'b00,
    KIND_BR  = 2'b01,
    KIND_ST  = 2'b10
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Oldest/youngest pointers and occupancy of the circular buffer.
module rob_ptrs #(
  parameter int DEPTH = 16,
  parameter int DW    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic [$clog2(DEPTH+1)-1:0] alloc_n,
  input  logic [$clog2(DEPTH+1)-1:0] ret_n,
  output logic [$clog2(DEPTH)-1:0]   head,
  output logic [$clog2(DEPTH)-1:0]   tail,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head  <= head + PTR_W'(ret_n);
      tail  <= tail + PTR_W'(alloc_n);
      count <= count + alloc_n - ret_n;
    end
  end

  assign full = (CNT_W'(DEPTH) - count) < CNT_W'(DW);
endmodule

// File: rtl/rob_entries.sv
// Per-slot state: status bits in reset flops, payload in plain arrays.
module rob_entries #(
  parameter int DEPTH  = 16,
  parameter int DW     = 2,
  parameter int CW     = 2,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(DEPTH)-1:0] head,
  input  logic [$clog2(DEPTH)-1:0] tail,
  input  logic [DW-1:0]            alloc_en,
  input  logic [2*DW-1:0]          alloc_kind,
  input  logic [AREG_W*DW-1:0]     alloc_areg,
  input  logic                     wb_en,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  input  logic [DATA_W-1:0]        wb_value,
  input  logic [ADDR_W-1:0]        wb_addr,
  input  logic                     wb_flag,
  output logic [CW-1:0]            rd_done,
  output logic [CW-1:0]            rd_flag,
  output logic [2*CW-1:0]          rd_kind,
  output logic [AREG_W*CW-1:0]     rd_areg,
  output logic [DATA_W*CW-1:0]     rd_val,
  output logic [ADDR_W*CW-1:0]     rd_addr
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  flag_q;
  logic [1:0]        kind_q [DEPTH];
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [PTR_W-1:0]  wr_idx [DW];

  always_comb begin
    for (int j = 0; j < DW; j++) wr_idx[j] = tail + PTR_W'(j);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      flag_q <= '0;
    end else begin
      for (int j = 0; j < DW; j++) begin
        if (alloc_en[j]) begin
          done_q[wr_idx[j]] <= 1'b0;
          flag_q[wr_idx[j]] <= 1'b0;
        end
      end
      if (wb_en) begin
        done_q[wb_idx] <= 1'b1;
        flag_q[wb_idx] <= wb_flag;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < DW; j++) begin
      if (alloc_en[j]) begin
        kind_q[wr_idx[j]] <= alloc_kind[2*j +: 2];
        areg_q[wr_idx[j]] <= alloc_areg[AREG_W*j +: AREG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wb_en) begin
      val_q[wb_idx]  <= wb_value;
      addr_q[wb_idx] <= wb_addr;
    end
  end

  for (genvar i = 0; i < CW; i++) begin : g_rd
    logic [PTR_W-1:0] ri;
    assign ri = head + PTR_W'(i);
    assign rd_done[i]                  = done_q[ri];
    assign rd_flag[i]                  = flag_q[ri];
    assign rd_kind[2*i +: 2]           = kind_q[ri];
    assign rd_areg[AREG_W*i +: AREG_W] = areg_q[ri];
    assign rd_val[DATA_W*i +: DATA_W]  = val_q[ri];
    assign rd_addr[ADDR_W*i +: ADDR_W] = addr_q[ri];
  end
endmodule

// File: rtl/rob_pick.sv
// Chooses the retirement group from the window at the oldest slot.
module rob_pick
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CW     = 2,
  parameter int ADDR_W = 32
) (
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [CW-1:0]              rd_done,
  input  logic [CW-1:0]              rd_flag,
  input  logic [2*CW-1:0]            rd_kind,
  input  logic [ADDR_W*CW-1:0]       rd_addr,
  output logic [CW-1:0]              ret_mask,
  output logic [$clog2(DEPTH+1)-1:0] ret_n,
  output logic                       flush_now,
  output logic [ADDR_W-1:0]          flush_tgt
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic go;

  always_comb begin
    go        = 1'b1;
    ret_mask  = '0;
    ret_n     = '0;
    flush_now = 1'b0;
    for (int i = 0; i < CW; i++) begin
      if (go) begin
        if ((CNT_W'(i) < count) && rd_done[i]) begin
          if (rd_flag[i]) begin
            flush_now = (i == 0);
            go        = 1'b0;
          end else begin
            ret_mask[i] = 1'b1;
            ret_n       = ret_n + CNT_W'(1);
            if (rd_kind[2*i +: 2] == KIND_BR) go = 1'b0;
          end
        end else begin
          go = 1'b0;
        end
      end
    end
  end

  assign flush_tgt = rd_addr[ADDR_W-1:0];
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DW     = 2,
  parameter int CW     = 2,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DW-1:0]            disp_vld,
  input  logic [2*DW-1:0]          disp_kind,
  input  logic [AREG_W*DW-1:0]     disp_areg,
  output logic                     full,
  output logic [$clog2(DEPTH)-1:0] alloc_base,
  input  logic                     wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  input  logic [DATA_W-1:0]        wb_value,
  input  logic [ADDR_W-1:0]        wb_addr,
  input  logic                     wb_mispred,
  input  logic                     wb_trap,
  output logic [CW-1:0]            ret_mask,
  output logic [CW-1:0]            rf_we,
  output logic [AREG_W*CW-1:0]     rf_waddr,
  output logic [DATA_W*CW-1:0]     rf_wdata,
  output logic [CW-1:0]            st_valid,
  output logic [ADDR_W*CW-1:0]     st_addr,
  output logic [DATA_W*CW-1:0]     st_data,
  output logic                     flush,
  output logic [ADDR_W-1:0]        flush_pc
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [PTR_W-1:0]      head, tail;
  logic [CNT_W-1:0]      count, alloc_n, ret_n;
  logic [DW-1:0]         alloc_en;
  logic                  wb_en;
  logic                  flush_now;
  logic [ADDR_W-1:0]     flush_tgt;
  logic [CW-1:0]         pick_mask;
  logic [CW-1:0]         rd_done, rd_flag;
  logic [2*CW-1:0]       rd_kind;
  logic [AREG_W*CW-1:0]  rd_areg;
  logic [DATA_W*CW-1:0]  rd_val;
  logic [ADDR_W*CW-1:0]  rd_addr;

  assign alloc_en   = (!full && !flush_now) ? disp_vld : '0;
  assign wb_en      = wb_valid && !flush_now;
  assign alloc_base = tail;

  always_comb begin
    alloc_n = '0;
    for (int j = 0; j < DW; j++) alloc_n = alloc_n + CNT_W'(alloc_en[j]);
  end

  rob_ptrs #(.DEPTH(DEPTH), .DW(DW)) u_ptrs (
    .clk(clk), .rst(rst), .clear(flush_now),
    .alloc_n(alloc_n), .ret_n(ret_n),
    .head(head), .tail(tail), .count(count), .full(full)
  );

  rob_entries #(
    .DEPTH(DEPTH), .DW(DW), .CW(CW),
    .AREG_W(AREG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_entries (
    .clk(clk), .rst(rst), .head(head), .tail(tail),
    .alloc_en(alloc_en), .alloc_kind(disp_kind), .alloc_areg(disp_areg),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_value(wb_value), .wb_addr(wb_addr),
    .wb_flag(wb_mispred | wb_trap),
    .rd_done(rd_done), .rd_flag(rd_flag), .rd_kind(rd_kind),
    .rd_areg(rd_areg), .rd_val(rd_val), .rd_addr(rd_addr)
  );

  rob_pick #(.DEPTH(DEPTH), .CW(CW), .ADDR_W(ADDR_W)) u_pick (
    .count(count), .rd_done(rd_done), .rd_flag(rd_flag),
    .rd_kind(rd_kind), .rd_addr(rd_addr),
    .ret_mask(pick_mask), .ret_n(ret_n),
    .flush_now(flush_now), .flush_tgt(flush_tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_mask <= '0;
      rf_we    <= '0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      st_valid <= '0;
      st_addr  <= '0;
      st_data  <= '0;
      flush    <= 1'b0;
      flush_pc <= '0;
    end else begin
      ret_mask <= pick_mask;
      flush    <= flush_now;
      if (flush_now) flush_pc <= flush_tgt;
      for (int i = 0; i < CW; i++) begin
        rf_we[i]    <= pick_mask[i] && (rd_kind[2*i +: 2] == KIND_OP);
        st_valid[i] <= pick_mask[i] && (rd_kind[2*i +: 2] == KIND_ST);
        rf_waddr[AREG_W*i +: AREG_W] <= rd_areg[AREG_W*i +: AREG_W];
        rf_wdata[DATA_W*i +: DATA_W] <= rd_val[DATA_W*i +: DATA_W];
        st_addr[ADDR_W*i +: ADDR_W]  <= rd_addr[ADDR_W*i +: ADDR_W];
        st_data[DATA_W*i +: DATA_W]  <= rd_val[DATA_W*i +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rob_retire_chk.sv
module rob_retire_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 2
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CW-1:0]            ret_mask,
  input logic [CW-1:0]            rf_we,
  input logic [CW-1:0]            st_valid,
  input logic                     flush,
  input logic                     full,
  input logic [$clog2(DEPTH)-1:0] alloc_base,
  input logic                     flush_now
);
  p_ret_prefix_r1: assert property (@(posedge clk) disable iff (rst)
    ((ret_mask & CW'(ret_mask + CW'(1))) == '0));

  p_flush_no_ret_r4: assert property (@(posedge clk) disable iff (rst)
    flush |-> (ret_mask == '0));

  p_flush_empty_r5: assert property (@(posedge clk) disable iff (rst)
    flush |-> (alloc_base == '0 && !full));

  p_we_on_ret_r6: assert property (@(posedge clk) disable iff (rst)
    ((rf_we & ~ret_mask) == '0));

  p_st_on_ret_r7: assert property (@(posedge clk) disable iff (rst)
    (((st_valid & ~ret_mask) == '0) && ((st_valid & rf_we) == '0)));

  p_full_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !flush_now) |=> $stable(alloc_base));
endmodule

bind rob_retire rob_retire_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ret_mask(ret_mask), .rf_we(rf_we),
  .st_valid(st_valid), .flush(flush), .full(full),
  .alloc_base(alloc_base), .flush_now(flush_now)
);

// File: tb/test_rob_retire.sv
module test_rob_retire;
  import rob_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam int DW     = 2;
  localparam int CW     = 2;
  localparam int AREG_W = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;
  localparam int PTR_W  = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0]        disp_vld  = '0;
  logic [2*DW-1:0]      disp_kind = '0;
  logic [AREG_W*DW-1:0] disp_areg = '0;
  logic                 full;
  logic [PTR_W-1:0]     alloc_base;
  logic                 wb_valid = 1'b0;
  logic [PTR_W-1:0]     wb_idx = '0;
  logic [DATA_W-1:0]    wb_value = '0;
  logic [ADDR_W-1:0]    wb_addr = '0;
  logic                 wb_mispred = 1'b0;
  logic                 wb_trap = 1'b0;
  logic [CW-1:0]        ret_mask, rf_we, st_valid;
  logic [AREG_W*CW-1:0] rf_waddr;
  logic [DATA_W*CW-1:0] rf_wdata, st_data;
  logic [ADDR_W*CW-1:0] st_addr;
  logic                 flush;
  logic [ADDR_W-1:0]    flush_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_retire #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .AREG_W(AREG_W),
               .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rob_retire (
    .clk(clk), .rst(rst), .disp_vld(disp_vld), .disp_kind(disp_kind),
    .disp_areg(disp_areg), .full(full), .alloc_base(alloc_base),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_value(wb_value),
    .wb_addr(wb_addr), .wb_mispred(wb_mispred), .wb_trap(wb_trap),
    .ret_mask(ret_mask), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .flush(flush), .flush_pc(flush_pc)
  );

  typedef struct packed {
    logic [1:0]        kind;
    logic [AREG_W-1:0] areg;
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
  } exp_t;

  exp_t              exp_q[$];
  int                grp_q[$];
  logic [ADDR_W-1:0] fl_q[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares every retired slot with the next expected item.
  always @(negedge clk) begin
    int   g;
    exp_t e;
    g = 0;
    if (!rst) begin
      for (int i = 0; i < CW; i++) begin
        if (rf_we[i] && !ret_mask[i]) chk(1'b0, "R6 write without retire", 64'(i), 64'hffff);
        if (st_valid[i] && !ret_mask[i]) chk(1'b0, "R7 store without retire", 64'(i), 64'hffff);
        if (ret_mask[i]) begin
          g++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected retirement", 64'(i), 64'hffff);
          end else begin
            e = exp_q.pop_front();
            case (e.kind)
              KIND_OP: chk(rf_we[i] && !st_valid[i] &&
                           rf_waddr[AREG_W*i +: AREG_W] == e.areg &&
                           rf_wdata[DATA_W*i +: DATA_W] == e.data,
                           "R6/R1 register retire",
                           {27'd0, rf_waddr[AREG_W*i +: AREG_W], rf_wdata[DATA_W*i +: DATA_W]},
                           {27'd0, e.areg, e.data});
              KIND_ST: chk(st_valid[i] && !rf_we[i] &&
                           st_addr[ADDR_W*i +: ADDR_W] == e.addr &&
                           st_data[DATA_W*i +: DATA_W] == e.data,
                           "R7 store retire",
                           {st_addr[ADDR_W*i +: ADDR_W], st_data[DATA_W*i +: DATA_W]},
                           {e.addr, e.data});
              default: chk(!rf_we[i] && !st_valid[i], "R3 branch retire",
                           {62'd0, rf_we[i], st_valid[i]}, 64'd0);
            endcase
          end
        end
      end
      if (g > 0) grp_q.push_back(g);
      if (flush) fl_q.push_back(flush_pc);
    end
  end

  task automatic disp(input logic [1:0] vld, input logic [1:0] k0, input logic [4:0] a0,
                      input logic [1:0] k1, input logic [4:0] a1);
    disp_vld  = vld;
    disp_kind = {k1, k0};
    disp_areg = {a1, a0};
    @(negedge clk);
    disp_vld = '0;
  endtask

  task automatic wb(input int idx, input logic [31:0] val, input logic [31:0] addr,
                    input bit mis, input bit trap);
    wb_valid = 1'b1; wb_idx = PTR_W'(idx); wb_value = val; wb_addr = addr;
    wb_mispred = mis; wb_trap = trap;
    @(negedge clk);
    wb_valid = 1'b0; wb_mispred = 1'b0; wb_trap = 1'b0;
  endtask

  task automatic push_op(input logic [4:0] a, input logic [31:0] v);
    exp_q.push_back('{kind: KIND_OP, areg: a, data: v, addr: '0});
  endtask
  task automatic push_st(input logic [31:0] ad, input logic [31:0] v);
    exp_q.push_back('{kind: KIND_ST, areg: '0, data: v, addr: ad});
  endtask
  task automatic push_br();
    exp_q.push_back('{kind: KIND_BR, areg: '0, data: '0, addr: '0});
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 60 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic chk_grps(input string req, input int n, input int g0, input int g1);
    chk(grp_q.size() == n, req, 64'(grp_q.size()), 64'(n));
    if (grp_q.size() == n && n > 0) chk(grp_q[0] == g0, req, 64'(grp_q[0]), 64'(g0));
    if (grp_q.size() == n && n > 1) chk(grp_q[1] == g1, req, 64'(grp_q[1]), 64'(g1));
    grp_q.delete();
  endtask

  task automatic chk_flush(input string req, input logic [31:0] pc);
    chk(fl_q.size() == 1, req, 64'(fl_q.size()), 64'd1);
    if (fl_q.size() == 1) chk(fl_q[0] == pc, req, 64'(fl_q[0]), 64'(pc));
    fl_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(alloc_base == '0 && !full && !flush, "R10 pointers and flags", {alloc_base, full, flush}, 64'd0);
    chk(ret_mask == '0 && rf_we == '0 && st_valid == '0, "R10 retire outputs",
        {ret_mask, rf_we, st_valid}, 64'd0);

    // R1, R2, R9: four plain ops, written back newest first
    disp(2'b11, KIND_OP, 5'd1, KIND_OP, 5'd2);
    disp(2'b11, KIND_OP, 5'd3, KIND_OP, 5'd4);
    chk(alloc_base == 4'd4, "R9 base after two groups", 64'(alloc_base), 64'd4);
    push_op(5'd1, 32'h11); push_op(5'd2, 32'h22); push_op(5'd3, 32'h33); push_op(5'd4, 32'h44);
    wb(3, 32'h44, 0, 0, 0); wb(2, 32'h33, 0, 0, 0); wb(1, 32'h22, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(grp_q.size() == 0, "R2 oldest unfinished blocks all", 64'(grp_q.size()), 64'd0);
    wb(0, 32'h11, 0, 0, 0);
    drain("R1 drain plain ops");
    chk_grps("R1 group sizes", 2, 2, 2);

    // R2: gap inside the window
    disp(2'b11, KIND_OP, 5'd5, KIND_OP, 5'd6);
    disp(2'b01, KIND_OP, 5'd7, KIND_OP, 5'd0);
    push_op(5'd5, 32'h55);
    wb(6, 32'h77, 0, 0, 0); wb(4, 32'h55, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk_grps("R2 stop at gap", 1, 1, 0);
    push_op(5'd6, 32'h66); push_op(5'd7, 32'h77);
    wb(5, 32'h66, 0, 0, 0);
    drain("R2 drain after gap");
    chk_grps("R2 rest retires", 1, 2, 0);

    // R3: branch first, then branch second
    disp(2'b11, KIND_BR, 5'd0, KIND_OP, 5'd8);
    push_br(); push_op(5'd8, 32'h88);
    wb(8, 32'h88, 0, 0, 0); wb(7, 0, 0, 0, 0);
    drain("R3 drain branch first");
    chk_grps("R3 branch first ends group", 2, 1, 1);
    disp(2'b11, KIND_OP, 5'd9, KIND_BR, 5'd0);
    disp(2'b11, KIND_OP, 5'd10, KIND_OP, 5'd11);
    push_op(5'd9, 32'h99); push_br(); push_op(5'd10, 32'haa); push_op(5'd11, 32'hbb);
    wb(12, 32'hbb, 0, 0, 0); wb(11, 32'haa, 0, 0, 0); wb(10, 0, 0, 0, 0); wb(9, 32'h99, 0, 0, 0);
    drain("R3 drain branch second");
    chk_grps("R3 branch second ends group", 2, 2, 2);

    // R7: store beside a plain op
    disp(2'b11, KIND_ST, 5'd0, KIND_OP, 5'd12);
    push_st(32'h100, 32'hdead); push_op(5'd12, 32'hcc);
    wb(14, 32'hcc, 0, 0, 0); wb(13, 32'hdead, 32'h100, 0, 0);
    drain("R7 drain store");
    chk_grps("R7 store group", 1, 2, 0);

    // R4, R5, R9: wrong-guess branch across the wrap
    disp(2'b11, KIND_OP, 5'd13, KIND_BR, 5'd0);
    disp(2'b01, KIND_OP, 5'd14, KIND_OP, 5'd0);
    chk(alloc_base == 4'd2, "R9 base wraps", 64'(alloc_base), 64'd2);
    push_op(5'd13, 32'hd1);
    wb(1, 32'he1, 0, 0, 0); wb(0, 0, 32'h4000, 1, 0); wb(15, 32'hd1, 0, 0, 0);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R4 op before branch retires", 64'(exp_q.size()), 64'd0);
    chk_grps("R4 flagged slot ends group", 1, 1, 0);
    chk_flush("R4 mispredict target", 32'h4000);
    chk(alloc_base == '0 && !full, "R5 emptied after flush", {alloc_base, full}, 64'd0);
    repeat (4) @(negedge clk);
    chk_grps("R5 nothing old retires", 0, 0, 0);

    // R4: exception in second window slot
    disp(2'b11, KIND_OP, 5'd15, KIND_OP, 5'd16);
    push_op(5'd15, 32'hf1);
    wb(1, 0, 32'h80, 0, 1); wb(0, 32'hf1, 0, 0, 0);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R4 op before trap retires", 64'(exp_q.size()), 64'd0);
    chk_grps("R4 trap group", 1, 1, 0);
    chk_flush("R4 trap target", 32'h80);

    // R8: fill to one free slot
    disp(2'b01, KIND_OP, 5'd17, KIND_OP, 5'd0);
    for (int k = 0; k < 6; k++) disp(2'b11, KIND_OP, 5'd18, KIND_OP, 5'd19);
    chk(!full, "R8 three free not full", 64'(full), 64'd0);
    disp(2'b11, KIND_OP, 5'd18, KIND_OP, 5'd19);
    chk(full, "R8 one free is full", 64'(full), 64'd1);
    chk(alloc_base == 4'd15, "R8 base at fill", 64'(alloc_base), 64'd15);
    disp(2'b11, KIND_OP, 5'd18, KIND_OP, 5'd19);
    chk(alloc_base == 4'd15, "R8 dispatch ignored when full", 64'(alloc_base), 64'd15);
    wb(0, 0, 32'h200, 0, 1);
    repeat (5) @(negedge clk);
    chk_flush("R5 flush from full", 32'h200);
    chk(alloc_base == '0 && !full, "R5 full cleared", {alloc_base, full}, 64'd0);
    chk_grps("R5 no retire from full", 0, 0, 0);

    // R5: normal operation after the flush
    disp(2'b11, KIND_OP, 5'd20, KIND_OP, 5'd21);
    push_op(5'd20, 32'h2020); push_op(5'd21, 32'h2121);
    wb(1, 32'h2121, 0, 0, 0); wb(0, 32'h2020, 0, 0, 0);
    drain("R5 drain after flush");
    chk_grps("R5 restart group", 1, 2, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule